// File: doc/BRIEF.md
# Cascaded FIFO Slice with Token Ring

A single FIFO slice built to be chained with identical copies into a deeper buffer. All slices of a chain see the same write strobe, read strobe and input data. Each slice holds a write token, a read token, both or neither, and only the holder of the matching token takes part in a transfer. Exactly one slice, selected by a static input, holds both tokens when reset ends. The others hold none.

A slice fills its storage from the first entry to the last. On the write into its last entry, it hands the write token to the next slice with a one-cycle pulse on its ring output. Reads drain the slices in the same ring order, and the read token moves in the same way. The ring output of each slice drives the ring input of the next, and the last slice closes the loop back to the first. Because one line carries both kinds of token, a receiving slice classifies an incoming pulse by the write strobe in that cycle.

The bus is valid/ready with one transfer per cycle. A write offer (`in_valid`) always takes priority over a read, so a slice never offers read data while `in_valid` is high. Back-pressure comes from the slices: the composite write ready is the OR of the per-slice `in_ready`, and the composite read valid is the OR of the per-slice `out_valid`. Read data from an idle slice is forced to zero, so the read buses can be ORed together. The active-low local empty and full flags are exported so they can be combined outside the slice.

Top module: `casc_fifo_slice`

## Requirements
- R1: After reset, a slice with `first_slice`=1 has `in_ready`=1 and `out_valid`=0. A slice with `first_slice`=0 has `in_ready`=0 and `out_valid`=0. Every slice shows `empty_n`=0, `full_n`=1 and `xp_out`=0.
- R2: `in_ready` is high exactly when the slice holds the write token and is not full. A word is stored only on a cycle with `in_valid` and `in_ready` both high.
- R3: In the cycle a slice stores into its last entry, `xp_out` is 1 in that same cycle. From the next cycle the slice gives up the write token (`in_ready`=0), and the next slice in the ring shows `in_ready`=1.
- R4: In the cycle a slice reads its last entry, `xp_out` is 1 in that same cycle. From the next cycle the read token belongs to the next slice.
- R5: A pulse on `xp_in` in a cycle with `in_valid`=1 delivers the write token. A pulse with `in_valid`=0 delivers the read token. A slice that has received only the write token keeps `out_valid`=0 even when it holds data.
- R6: At most one transfer happens per cycle, and writes win. `out_valid` is 0 whenever `in_valid` is 1, so asserting both strobes performs only the write.
- R7: Words leave the chain in the order they entered, across slice boundaries.
- R8: `full_n` is 0 exactly when the slice holds DEPTH words. `empty_n` is 0 exactly when it holds none.
- R9: `out_data` is all zeros whenever `out_valid` is 0.
- R10: When every slice in the ring is full, the composite `in_ready` is 0. A write offered in that state is dropped and does not appear in the read stream.
- R11: Both pointers wrap to the first entry after the last entry. A second pass around the ring keeps the order correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears both pointers and the word count |
| first_slice | input | 1 | Static; 1 makes this slice hold both tokens after reset |
| xp_in | input | 1 | Token pulse from the previous slice's `xp_out` |
| xp_out | output | 1 | Token pulse to the next slice, raised when the last entry is written or read |
| in_valid | input | 1 | Shared write offer |
| in_ready | output | 1 | This slice accepts the offered word |
| in_data | input | WIDTH | Shared write data |
| out_ready | input | 1 | Shared read strobe |
| out_valid | output | 1 | This slice offers a word |
| out_data | output | WIDTH | Offered word; zero when `out_valid` is 0 |
| empty_n | output | 1 | Low when the slice holds no word |
| full_n | output | 1 | Low when the slice holds DEPTH words |

## Verification
`xp_out` is combinational from the handshake, so it is due in the same cycle as the transfer that raises it. `in_ready`, `out_valid`, `empty_n` and `full_n` are due one clock edge after the transfer or token pulse that changes them. The bench drives inputs on the falling edge and checks `xp_out` and the handshake 1 ns later, before the rising edge that commits the transfer. It checks token ownership and flags just after the following falling edge, one rising edge later. Read data is checked in the cycle it is offered, before the edge that consumes it.

// File: rtl/casc_fifo_pkg.sv
package casc_fifo_pkg;

  // Classification of a pulse arriving on the ring input.
  typedef enum logic {
    TOK_READ  = 1'b0,
    TOK_WRITE = 1'b1
  } tok_kind_e;

  // Pointer width for a storage of the given depth (at least one bit).
  function automatic int unsigned ptr_bits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  // Counter width able to hold the values 0..depth.
  function automatic int unsigned cnt_bits(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction

  function automatic bit is_pow2(input int unsigned depth);
    return (depth != 0) && ((depth & (depth - 1)) == 0);
  endfunction

endpackage

// File: rtl/casc_slice_store.sv
module casc_slice_store
  import casc_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_fire,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_fire,
  output logic [WIDTH-1:0] rd_data,
  output logic             wr_at_last,
  output logic             rd_at_last,
  output logic             is_empty,
  output logic             is_full
);
  localparam int unsigned AW = ptr_bits(DEPTH);
  localparam int unsigned CW = cnt_bits(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr, wptr_nx, rptr_nx;
  logic [CW-1:0]    count;

  assign wr_at_last = (wptr == LAST);
  assign rd_at_last = (rptr == LAST);

  // Pointer advance: natural wrap for power-of-two depths, compare otherwise.
  generate
    if (is_pow2(DEPTH)) begin : g_wrap_nat
      assign wptr_nx = wptr + AW'(1);
      assign rptr_nx = rptr + AW'(1);
    end else begin : g_wrap_cmp
      assign wptr_nx = wr_at_last ? '0 : wptr + AW'(1);
      assign rptr_nx = rd_at_last ? '0 : rptr + AW'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_fire) wptr <= wptr_nx;
      if (rd_fire) rptr <= rptr_nx;
      unique case ({wr_fire, rd_fire})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign rd_data  = mem[rptr];
  assign is_empty = (count == '0);
  assign is_full  = (count == FULL_CNT);

endmodule

// File: rtl/casc_token_ctrl.sv
module casc_token_ctrl
  import casc_fifo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic first_slice,
  input  logic xp_in,
  input  logic wr_strobe,
  input  logic wr_pass,
  input  logic rd_pass,
  output logic wr_tok,
  output logic rd_tok,
  output logic xp_out
);
  tok_kind_e in_kind;

  // The shared write strobe tells which token an incoming pulse carries.
  assign in_kind = wr_strobe ? TOK_WRITE : TOK_READ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_tok <= first_slice;
      rd_tok <= first_slice;
    end else begin
      wr_tok <= (wr_tok & ~wr_pass) | (xp_in & (in_kind == TOK_WRITE));
      rd_tok <= (rd_tok & ~rd_pass) | (xp_in & (in_kind == TOK_READ));
    end
  end

  // A write pass needs wr_strobe, and a read pass needs it low, so they never coincide.
  assign xp_out = wr_pass | rd_pass;

endmodule

// File: rtl/casc_fifo_slice.sv
module casc_fifo_slice
  import casc_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first_slice,
  input  logic             xp_in,
  output logic             xp_out,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  output logic             empty_n,
  output logic             full_n
);
  logic             wr_tok, rd_tok;
  logic             wr_fire, rd_fire;
  logic             wr_at_last, rd_at_last;
  logic             is_empty, is_full;
  logic [WIDTH-1:0] rd_data;

  assign in_ready  = wr_tok & ~is_full;
  assign out_valid = rd_tok & ~is_empty & ~in_valid;
  assign wr_fire   = in_valid & in_ready;
  assign rd_fire   = out_valid & out_ready;
  assign out_data  = out_valid ? rd_data : '0;
  assign empty_n   = ~is_empty;
  assign full_n    = ~is_full;

  casc_slice_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_fire    (wr_fire),
    .wr_data    (in_data),
    .rd_fire    (rd_fire),
    .rd_data    (rd_data),
    .wr_at_last (wr_at_last),
    .rd_at_last (rd_at_last),
    .is_empty   (is_empty),
    .is_full    (is_full)
  );

  casc_token_ctrl u_tok (
    .clk         (clk),
    .rst_n       (rst_n),
    .first_slice (first_slice),
    .xp_in       (xp_in),
    .wr_strobe   (in_valid),
    .wr_pass     (wr_fire & wr_at_last),
    .rd_pass     (rd_fire & rd_at_last),
    .wr_tok      (wr_tok),
    .rd_tok      (rd_tok),
    .xp_out      (xp_out)
  );

endmodule

// File: rtl/casc_fifo_slice_chk.sv
module casc_fifo_slice_chk
  import casc_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xp_out,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_ready,
  input logic             out_valid,
  input logic [WIDTH-1:0] out_data,
  input logic             empty_n,
  input logic             full_n
);
  localparam int unsigned CW = cnt_bits(DEPTH);

  // Occupancy rebuilt from the port handshakes.
  logic [CW-1:0] occ;
  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else if (in_valid && in_ready) occ <= occ + CW'(1);
    else if (out_valid && out_ready) occ <= occ - CW'(1);
  end

  a_r6_one_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> !out_valid);

  a_r9_idle_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == '0));

  a_r8_full_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> !in_ready);

  a_r8_empty_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |-> !out_valid);

  a_r8_full_tracks_occ: assert property (@(posedge clk) disable iff (!rst_n)
    full_n == (occ != CW'(DEPTH)));

  a_r8_empty_tracks_occ: assert property (@(posedge clk) disable iff (!rst_n)
    empty_n == (occ != '0));

  a_r3_pulse_needs_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    xp_out |-> ((in_valid && in_ready) || (out_valid && out_ready)));

  a_r2_write_advances_occ: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (occ == $past(occ) + CW'(1)));

endmodule

bind casc_fifo_slice casc_fifo_slice_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .xp_out    (xp_out),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .empty_n   (empty_n),
  .full_n    (full_n)
);

// File: tb/tb_casc_fifo_slice.sv
`timescale 1ns/1ps
module tb_casc_fifo_slice;
  localparam int N = 3;
  localparam int D = 4;
  localparam int W = 8;
  localparam int NV = 24;
  // Bit 8: 1 = write, 0 = read; bits 7:0: data written or expected.
  localparam logic [8:0] VEC [NV] = '{
    9'h111, 9'h122, 9'h133, 9'h144, 9'h155, 9'h166,
    9'h177, 9'h188, 9'h199, 9'h1AA, 9'h1BB, 9'h1CC,
    9'h011, 9'h022, 9'h033, 9'h044, 9'h055, 9'h066,
    9'h077, 9'h088, 9'h099, 9'h0AA, 9'h0BB, 9'h0CC
  };

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0, out_ready = 0;
  logic [W-1:0] in_data = '0;
  logic [N-1:0] xp_out, in_ready, out_valid, empty_n, full_n;
  logic [W-1:0] out_data [N];
  logic [W-1:0] out_data_c;
  logic in_ready_c, out_valid_c;
  logic [N-1:0] last_xp;
  logic last_ov, last_od0;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  for (genvar g = 0; g < N; g++) begin : g_sl
    casc_fifo_slice #(.DEPTH(D), .WIDTH(W)) dut (
      .clk(clk), .rst_n(rst_n), .first_slice(g == 0),
      .xp_in(xp_out[(g + N - 1) % N]), .xp_out(xp_out[g]),
      .in_valid(in_valid), .in_ready(in_ready[g]), .in_data(in_data),
      .out_ready(out_ready), .out_valid(out_valid[g]), .out_data(out_data[g]),
      .empty_n(empty_n[g]), .full_n(full_n[g])
    );
  end

  always_comb begin
    out_data_c = '0;
    for (int i = 0; i < N; i++) out_data_c = out_data_c | out_data[i];
  end
  assign in_ready_c  = |in_ready;
  assign out_valid_c = |out_valid;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called just after a falling edge; returns just after the next one.
  task automatic do_write(input logic [W-1:0] v, input bit expect_ok);
    in_valid = 1; out_ready = 0; in_data = v;
    #1;
    chk("R2 write ready", in_ready_c, expect_ok);
    last_xp = xp_out; last_ov = out_valid_c; last_od0 = (out_data[0] == '0);
    @(negedge clk);
    in_valid = 0;
    #1;
  endtask

  task automatic do_read(input logic [W-1:0] exp);
    in_valid = 0; out_ready = 1;
    #1;
    chk("R7 read valid", out_valid_c, 1);
    chk("R7 read order", out_data_c, exp);
    last_xp = xp_out;
    @(negedge clk);
    out_ready = 0;
    #1;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 in_ready", in_ready, 3'b001);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 empty_n", empty_n, 0);
    chk("R1 full_n", full_n, 3'b111);
    chk("R1 xp_out", xp_out, 0);

    for (int i = 0; i < NV; i++) begin
      if (i == 12) begin
        // R10: whole ring full, offered word dropped
        chk("R10 ring full ready", in_ready_c, 0);
        chk("R8 all full", full_n, 0);
        do_write(8'hEE, 0);
      end
      if (VEC[i][8]) do_write(VEC[i][7:0], 1);
      else do_read(VEC[i][7:0]);
      if (i == 3) begin
        chk("R3 xp_out on last write", last_xp, 3'b001);
        chk("R3 write token moved", in_ready, 3'b010);
        chk("R8 slice0 full", full_n[0], 0);
        chk("R8 slice0 not empty", empty_n[0], 1);
      end
      if (i == 4) chk("R5 write token only", out_valid[1], 0);
      if (i == 15) begin
        chk("R4 xp_out on last read", last_xp, 3'b001);
        chk("R4 read token moved", out_valid, 3'b010);
      end
    end
    chk("R8 all empty", empty_n, 0);
    chk("R11 write token back", in_ready, 3'b001);
    chk("R9 idle zero data", out_data_c, 0);

    // Second lap: wrap of pointers and write priority.
    for (int i = 0; i < 6; i++) begin
      do_write(8'hA0 + 8'(i), 1);
      if (i == 2) begin
        chk("R6 no read during write", last_ov, 0);
        chk("R9 zero data during write", last_od0, 1);
      end
    end
    // Both strobes at once: only the write happens.
    in_valid = 1; out_ready = 1; in_data = 8'hA6;
    #1;
    chk("R6 both strobes valid", out_valid_c, 0);
    @(negedge clk);
    in_valid = 0; out_ready = 0;
    #1;
    for (int i = 0; i < 7; i++) do_read(8'hA0 + 8'(i));
    chk("R11 second lap drained", out_valid_c, 0);
    chk("R11 empty after lap", empty_n, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule